// File: doc/BRIEF.md
# Multiphase Phase-to-Digital Decoder

This block turns the instantaneous state of a multiphase oscillator into a binary phase word. Its 32 tap inputs are captured together on each reference clock edge. The captured snapshot is a circular pseudo-thermometer pattern: a contiguous run of ones and a run of zeros, with the position of the run marking the phase. The decoder removes isolated wrong bits from the snapshot. It then rotates the cleaned pattern by a programmable amount, which aligns the fractional phase with an external integer cycle counter. Next it finds the position of the run's rising boundary. That position indexes one of two programmable tables, one for each rotation direction, which give the fractional phase.

The direction comes from two taps that are not adjacent. When the first of them is seen to go from 0 to 1 between reference samples, the state of the second tells which way the wave travels. The fractional result is then joined to the integer count. If the fraction jumps by more than half a cycle while the counter stays unchanged, the integer part is moved by one to remove the 2π glitch.

The tables reset to a linear ramp. A calibration engine outside the block can later overwrite them with values that correct nonlinearity.

Top module: `tapcode_phase_decoder`

## Requirements
- R1: `taps_i` and `count_i` are captured on the same clock edge. Their result appears on `phase_o` after the third rising edge counted from the edge that captured them.
- R2: Before decoding, each tap bit that differs from both of its circular neighbours (bits i-1 and i+1, with index 31 next to index 0) is inverted. Every other bit passes unchanged. All bits are judged on the raw capture.
- R3: The cleaned code is rotated so that rotated bit j equals cleaned bit (j + `rot_i`) mod 32. The table index is the lowest j at which rotated bit j is 1 and rotated bit (j-1) mod 32 is 0. If no such j exists (all zeros or all ones), the index is 0.
- R4: The direction bit (0 = clockwise table, 1 = counter-clockwise table) resets to 0. In a cycle where cleaned tap 0 is 1 and was 0 in the previous capture, the direction takes the value of cleaned tap 8, and that new value already applies to the current capture. In any other cycle it holds.
- R5: The fraction is entry [index] of the table selected by the direction. After reset, entry e of both tables holds e*256/32.
- R6: When `lut_we_i` is high at a rising edge, entry `lut_idx_i` of table `lut_dir_i` (0 = clockwise, 1 = counter-clockwise) takes `lut_val_i`. Captures decoded after that edge use the new value.
- R7: Let f be the new fraction and p the previous fraction. If p > f, p - f > 128, and `count_i` equals the previous capture's count, the integer part is the count plus 1, modulo 4096.
- R8: If f > p, f - p > 128, and `count_i` equals the previous capture's count, the integer part is the count minus 1, modulo 4096.
- R9: In all other cases the integer part is the captured count unchanged. This includes a jump of exactly 128, a changed counter, and the first capture after reset.
- R10: `valid_o` is 0 during reset. It rises after the third rising edge following reset release and then stays high. `phase_o` is 0 during reset.
- R11: `phase_o` holds the integer part in bits 19:8 and the fraction in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; every register uses its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| taps_i | input | 32 | Oscillator phase taps |
| count_i | input | 12 | Integer oscillator cycle count |
| rot_i | input | 5 | Circular rotation applied to the cleaned code |
| lut_we_i | input | 1 | Table write strobe |
| lut_dir_i | input | 1 | Table chosen for the write: 0 clockwise, 1 counter-clockwise |
| lut_idx_i | input | 5 | Entry written |
| lut_val_i | input | 8 | Value written |
| phase_o | output | 20 | Combined phase word {integer, fraction} |
| valid_o | output | 1 | Output word is meaningful |

## Verification
A captured pattern and count come out on `phase_o` three rising edges after they are applied. The bench applies each stimulus at a falling edge, waits exactly three rising edges, and compares at the following falling edge. After that point the repeated capture is compared with itself and would show no glitch, so this is the only cycle in which the glitch correction against the previous pattern is visible. Rotation and table values are read in the decode stage, one edge after capture. The bench's reference model therefore also re-derives the previous fraction as the repeated old pattern decodes under the new rotation and tables. The validity flag is checked at each of the first three edges after reset release.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

   typedef enum logic {
      DIR_CW  = 1'b0,
      DIR_CCW = 1'b1
   } rot_dir_e;

   localparam int unsigned NUM_DIRS = 2;

endpackage

// File: rtl/tpd_code_cond.sv
module tpd_code_cond #(
   parameter int N_TAPS  = 32,
   parameter int IDX_W   = $clog2(N_TAPS),
   parameter bit ROT_LOG = 1'b1
) (
   input  logic [N_TAPS-1:0] raw_i,
   input  logic [IDX_W-1:0]  rot_i,
   output logic [N_TAPS-1:0] clean_o,
   output logic [IDX_W-1:0]  idx_o
);

   // majority of each bit and its two circular neighbours
   for (genvar g = 0; g < N_TAPS; g++) begin : g_maj
      localparam int LO = (g + N_TAPS - 1) % N_TAPS;
      localparam int HI = (g + 1) % N_TAPS;
      assign clean_o[g] = (raw_i[g] & raw_i[LO]) |
                          (raw_i[g] & raw_i[HI]) |
                          (raw_i[LO] & raw_i[HI]);
   end

   logic [N_TAPS-1:0] rot_code;

   if (ROT_LOG) begin : g_log
      logic [N_TAPS-1:0] lvl [IDX_W+1];
      assign lvl[0] = clean_o;
      for (genvar s = 0; s < IDX_W; s++) begin : g_stage
         localparam int SH = 2 ** s;
         assign lvl[s+1] = rot_i[s] ? {lvl[s][SH-1:0], lvl[s][N_TAPS-1:SH]} : lvl[s];
      end
      assign rot_code = lvl[IDX_W];
   end else begin : g_mux
      always_comb begin
         for (int j = 0; j < N_TAPS; j++) begin
            rot_code[j] = clean_o[(j + int'(rot_i)) % N_TAPS];
         end
      end
   end

   // lowest rising boundary of the rotated run
   always_comb begin
      idx_o = '0;
      for (int j = N_TAPS - 1; j >= 0; j--) begin
         if (rot_code[j] && !rot_code[(j + N_TAPS - 1) % N_TAPS]) begin
            idx_o = IDX_W'(j);
         end
      end
   end

endmodule

// File: rtl/tpd_dir_detect.sv
module tpd_dir_detect
   import tpd_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic lead_i,
   input  logic far_i,
   output logic dir_o,
   output logic hold_o,
   output logic rise_o
);

   logic     lead_prev_q;
   rot_dir_e dir_q;

   assign rise_o = lead_i & ~lead_prev_q;
   assign dir_o  = rise_o ? far_i : dir_q;
   assign hold_o = dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_prev_q <= 1'b0;
         dir_q       <= DIR_CW;
      end else begin
         lead_prev_q <= lead_i;
         dir_q       <= rot_dir_e'(dir_o);
      end
   end

endmodule

// File: rtl/tpd_lut_bank.sv
module tpd_lut_bank
   import tpd_pkg::*;
#(
   parameter int N_TAPS = 32,
   parameter int FRAC_W = 8,
   parameter int IDX_W  = $clog2(N_TAPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              wr_dir_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [FRAC_W-1:0] wr_val_i,
   input  logic              rd_dir_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic [FRAC_W-1:0] rd_val_o
);

   logic [FRAC_W-1:0] tab_q [NUM_DIRS][N_TAPS];

   for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
      for (genvar e = 0; e < N_TAPS; e++) begin : g_ent
         localparam logic [FRAC_W-1:0] INIT = FRAC_W'((e * (2 ** FRAC_W)) / N_TAPS);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tab_q[d][e] <= INIT;
            end else if (wr_en_i && (wr_dir_i == 1'(d)) && (wr_idx_i == IDX_W'(e))) begin
               tab_q[d][e] <= wr_val_i;
            end
         end
      end
   end

   assign rd_val_o = tab_q[rd_dir_i][rd_idx_i];

endmodule

// File: rtl/tpd_wrap_fix.sv
module tpd_wrap_fix #(
   parameter int FRAC_W = 8,
   parameter int INT_W  = 12
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic [FRAC_W-1:0]       frac_i,
   input  logic [INT_W-1:0]        cnt_i,
   output logic [INT_W+FRAC_W-1:0] phase_o,
   output logic                    vld_o
);

   localparam logic [FRAC_W-1:0] HALF = FRAC_W'(2 ** (FRAC_W - 1));

   logic [FRAC_W-1:0]       prev_frac_q;
   logic [INT_W-1:0]        prev_cnt_q;
   logic                    prev_ok_q;
   logic [INT_W+FRAC_W-1:0] out_q;
   logic                    vld_q;

   logic [FRAC_W-1:0] drop, climb;
   logic              fwd, bwd, still;
   logic [INT_W-1:0]  int_fix;

   assign drop  = prev_frac_q - frac_i;
   assign climb = frac_i - prev_frac_q;
   assign fwd   = prev_ok_q && (prev_frac_q > frac_i) && (drop > HALF);
   assign bwd   = prev_ok_q && (frac_i > prev_frac_q) && (climb > HALF);
   assign still = (cnt_i == prev_cnt_q);

   always_comb begin
      int_fix = cnt_i;
      if (still && fwd) begin
         int_fix = cnt_i + INT_W'(1);
      end else if (still && bwd) begin
         int_fix = cnt_i - INT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_frac_q <= '0;
         prev_cnt_q  <= '0;
         prev_ok_q   <= 1'b0;
         out_q       <= '0;
         vld_q       <= 1'b0;
      end else begin
         vld_q <= vld_i;
         if (vld_i) begin
            out_q       <= {int_fix, frac_i};
            prev_frac_q <= frac_i;
            prev_cnt_q  <= cnt_i;
            prev_ok_q   <= 1'b1;
         end
      end
   end

   assign phase_o = out_q;
   assign vld_o   = vld_q;

endmodule

// File: rtl/tapcode_phase_decoder.sv
module tapcode_phase_decoder #(
   parameter int N_TAPS  = 32,
   parameter int FRAC_W  = 8,
   parameter int INT_W   = 12,
   parameter int DIR_GAP = 8,
   parameter bit ROT_LOG = 1'b1,
   parameter int IDX_W   = $clog2(N_TAPS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_TAPS-1:0]       taps_i,
   input  logic [INT_W-1:0]        count_i,
   input  logic [IDX_W-1:0]        rot_i,
   input  logic                    lut_we_i,
   input  logic                    lut_dir_i,
   input  logic [IDX_W-1:0]        lut_idx_i,
   input  logic [FRAC_W-1:0]       lut_val_i,
   output logic [INT_W+FRAC_W-1:0] phase_o,
   output logic                    valid_o
);

   if (N_TAPS < 4 || (2 ** IDX_W) != N_TAPS) begin : g_chk_taps
      $error("N_TAPS must be a power of two of at least 4");
   end
   if (DIR_GAP < 2 || DIR_GAP > N_TAPS - 2) begin : g_chk_gap
      $error("DIR_GAP must pick a tap not adjacent to tap 0");
   end
   if (FRAC_W < 2 || INT_W < 2) begin : g_chk_w
      $error("FRAC_W and INT_W must be at least 2");
   end

   // stage 1: capture
   logic [N_TAPS-1:0] s1_code_q;
   logic [INT_W-1:0]  s1_cnt_q;
   logic              s1_vld_q;

   // stage 2: decode
   logic [FRAC_W-1:0] s2_frac_q;
   logic [INT_W-1:0]  s2_cnt_q;
   logic              s2_vld_q;

   logic [N_TAPS-1:0] clean;
   logic [IDX_W-1:0]  run_idx;
   logic              dir_now, dir_hold, tap0_rise;
   logic [FRAC_W-1:0] lut_frac;

   tpd_code_cond #(
      .N_TAPS (N_TAPS),
      .IDX_W  (IDX_W),
      .ROT_LOG(ROT_LOG)
   ) u_cond (
      .raw_i  (s1_code_q),
      .rot_i  (rot_i),
      .clean_o(clean),
      .idx_o  (run_idx)
   );

   tpd_dir_detect u_dir (
      .clk   (clk),
      .rst_n (rst_n),
      .lead_i(clean[0]),
      .far_i (clean[DIR_GAP]),
      .dir_o (dir_now),
      .hold_o(dir_hold),
      .rise_o(tap0_rise)
   );

   tpd_lut_bank #(
      .N_TAPS(N_TAPS),
      .FRAC_W(FRAC_W),
      .IDX_W (IDX_W)
   ) u_lut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (lut_we_i),
      .wr_dir_i(lut_dir_i),
      .wr_idx_i(lut_idx_i),
      .wr_val_i(lut_val_i),
      .rd_dir_i(dir_now),
      .rd_idx_i(run_idx),
      .rd_val_o(lut_frac)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_code_q <= '0;
         s1_cnt_q  <= '0;
         s1_vld_q  <= 1'b0;
         s2_frac_q <= '0;
         s2_cnt_q  <= '0;
         s2_vld_q  <= 1'b0;
      end else begin
         s1_code_q <= taps_i;
         s1_cnt_q  <= count_i;
         s1_vld_q  <= 1'b1;
         s2_frac_q <= lut_frac;
         s2_cnt_q  <= s1_cnt_q;
         s2_vld_q  <= s1_vld_q;
      end
   end

   // stage 3: combine and glitch fix
   tpd_wrap_fix #(
      .FRAC_W(FRAC_W),
      .INT_W (INT_W)
   ) u_wrap (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (s2_vld_q),
      .frac_i (s2_frac_q),
      .cnt_i  (s2_cnt_q),
      .phase_o(phase_o),
      .vld_o  (valid_o)
   );

endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
   parameter int FRAC_W = 8,
   parameter int INT_W  = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [INT_W-1:0]        count_i,
   input logic [INT_W+FRAC_W-1:0] phase_o,
   input logic                    valid_o,
   input logic                    dir_hold,
   input logic                    tap0_rise
);

   logic [1:0]       since_q;
   logic [INT_W-1:0] c1_q, c2_q, c3_q;
   logic [INT_W-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         c1_q    <= '0;
         c2_q    <= '0;
         c3_q    <= '0;
      end else begin
         if (since_q != 2'd3) since_q <= since_q + 2'd1;
         c1_q <= count_i;
         c2_q <= c1_q;
         c3_q <= c2_q;
      end
   end

   assign gap = phase_o[INT_W+FRAC_W-1:FRAC_W] - c3_q;

   a_r10_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o == (since_q == 2'd3));

   a_r10_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> valid_o);

   // R7 and R8: the integer part never moves more than one from the captured count
   a_r7_r8_int_step: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (gap == '0 || gap == INT_W'(1) || gap == '1));

   a_r9_flat_frac_no_fix: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(valid_o) && (phase_o[FRAC_W-1:0] == $past(phase_o[FRAC_W-1:0])))
      |-> (gap == '0));

   a_r4_dir_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dir_hold) |-> $past(tap0_rise));

endmodule

bind tapcode_phase_decoder tpd_checker #(
   .FRAC_W(FRAC_W),
   .INT_W (INT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .count_i  (count_i),
   .phase_o  (phase_o),
   .valid_o  (valid_o),
   .dir_hold (dir_hold),
   .tap0_rise(tap0_rise)
);

// File: tb/sim_tapcode_phase_decoder.sv
`timescale 1ns/1ps
module sim_tapcode_phase_decoder;

   localparam int N  = 32;
   localparam int F  = 8;
   localparam int IW = 12;
   localparam int G  = 8;
   localparam int XW = 5;
   localparam int PW = IW + F;
   localparam int HALF = 128;
   localparam int WD_LIMIT = 100000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  taps = '0;
   logic [IW-1:0] cnt = '0;
   logic [XW-1:0] rot = '0;
   logic          lut_we = 1'b0;
   logic          lut_dir = 1'b0;
   logic [XW-1:0] lut_idx = '0;
   logic [F-1:0]  lut_val = '0;
   logic [PW-1:0] phase;
   logic          valid;

   always #2.5 clk = ~clk;

   tapcode_phase_decoder #(.N_TAPS(N), .FRAC_W(F), .INT_W(IW), .DIR_GAP(G)) u0 (
      .clk(clk), .rst_n(rst_n), .taps_i(taps), .count_i(cnt), .rot_i(rot),
      .lut_we_i(lut_we), .lut_dir_i(lut_dir), .lut_idx_i(lut_idx), .lut_val_i(lut_val),
      .phase_o(phase), .valid_o(valid)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   // reference model state
   logic [F-1:0]  m_tab [2][N];
   bit            m_t0 = 1'b0;
   bit            m_dir = 1'b0;
   bit            m_have = 1'b0;
   int            m_pf = 0;
   logic [IW-1:0] m_pc = '0;
   logic [N-1:0]  m_code = '0;

   task automatic check(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == WD_LIMIT) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   function automatic logic [N-1:0] run_at(int p);
      logic [N-1:0] r = '0;
      for (int k = 0; k < N/2; k++) r[(p + k) % N] = 1'b1;
      return r;
   endfunction

   function automatic logic [N-1:0] fix(logic [N-1:0] b);
      logic [N-1:0] o;
      for (int i = 0; i < N; i++) begin
         logic l, r;
         l = b[(i + N - 1) % N];
         r = b[(i + 1) % N];
         o[i] = (b[i] != l && b[i] != r) ? ~b[i] : b[i];
      end
      return o;
   endfunction

   function automatic int edge_of(logic [N-1:0] c, int r);
      for (int j = 0; j < N; j++) begin
         if (c[(j + r) % N] && !c[(j + r + N - 1) % N]) return j;
      end
      return 0;
   endfunction

   task automatic check_vec(logic [N-1:0] code, logic [IW-1:0] c, logic [XW-1:0] r, string tag);
      logic [N-1:0]  fx;
      int            f;
      logic [IW-1:0] ie;
      if (m_have) m_pf = int'(m_tab[m_dir][edge_of(fix(m_code), int'(r))]);
      fx = fix(code);
      if (!m_t0 && fx[0]) m_dir = fx[G];
      m_t0 = fx[0];
      f = int'(m_tab[m_dir][edge_of(fx, int'(r))]);
      ie = c;
      if (m_have && c == m_pc) begin
         if (m_pf > f && m_pf - f > HALF) ie = c + IW'(1);
         else if (f > m_pf && f - m_pf > HALF) ie = c - IW'(1);
      end
      check(tag, {valid, phase}, {1'b1, ie, F'(f)});
      m_have = 1'b1;
      m_pf = f;
      m_pc = c;
      m_code = code;
   endtask

   task automatic run_vec(logic [N-1:0] code, logic [IW-1:0] c, logic [XW-1:0] r, string tag);
      @(negedge clk);
      lut_we = 1'b0;
      taps = code;
      cnt = c;
      rot = r;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_vec(code, c, r, tag);
   endtask

   task automatic put(bit d, int i, logic [F-1:0] v);
      @(negedge clk);
      lut_we = 1'b1;
      lut_dir = d;
      lut_idx = XW'(i);
      lut_val = v;
      m_tab[d][i] = v;
      @(posedge clk);
   endtask

   initial begin
      for (int d = 0; d < 2; d++)
         for (int e = 0; e < N; e++) m_tab[d][e] = F'(e * 256 / N);

      // R10 / R11: reset state
      taps = run_at(0);
      cnt = 12'd10;
      rot = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10 reset", {valid, phase}, '0);

      // R1 / R10: latency after release
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R10 edge1", {20'd0, valid}, '0);
      @(posedge clk); @(negedge clk);
      check("R10 edge2", {20'd0, valid}, '0);
      @(posedge clk); @(negedge clk);
      check_vec(run_at(0), 12'd10, 5'd0, "R1 first capture");

      // R7 / R8 / R9 glitch handling
      run_vec(run_at(28), 12'd50, 5'd0, "R11 setup");
      run_vec(run_at(2), 12'd50, 5'd0, "R7 forward wrap");
      run_vec(run_at(2), 12'd50, 5'd0, "R9 repeat");
      run_vec(run_at(28), 12'd50, 5'd0, "R8 backward wrap");
      run_vec(run_at(2), 12'd51, 5'd0, "R9 counter moved");
      run_vec(run_at(0), 12'd51, 5'd0, "R9 setup");
      run_vec(run_at(16), 12'd51, 5'd0, "R9 exact half");
      run_vec(run_at(28), 12'd4095, 5'd0, "R11 setup");
      run_vec(run_at(2), 12'd4095, 5'd0, "R7 rollover");

      // R2 bubble correction
      for (int p = 0; p < N; p++)
         for (int k = 0; k < N; k++)
            run_vec(run_at(p) ^ (N'(1) << k), 12'd300, 5'd0, "R2 bubble");
      run_vec(N'(1) << 16, 12'd300, 5'd0, "R2 lone one");

      // R3 / R5 exhaustive position and rotation
      for (int r = 0; r < N; r++)
         for (int p = 0; p < N; p++)
            run_vec(run_at(p), 12'd200, XW'(r), "R3/R5 sweep");
      run_vec('0, 12'd7, 5'd3, "R3 all zero");
      run_vec('1, 12'd7, 5'd3, "R3 all one");

      // R6 table write
      put(1'b0, 5, 8'hAB);
      put(1'b1, 5, 8'hAB);
      run_vec(run_at(5), 12'd9, 5'd0, "R6 written entry");

      // R4 direction with distinct tables
      for (int i = 0; i < N; i++) put(1'b1, i, F'(8 * i + 3));
      run_vec(run_at(16), 12'd20, 5'd0, "R4 tap0 low");
      run_vec(run_at(20), 12'd21, 5'd0, "R4 rise clockwise");
      run_vec(run_at(16), 12'd22, 5'd0, "R4 hold");
      run_vec(run_at(28), 12'd23, 5'd0, "R4 rise counter-clockwise");
      run_vec(run_at(27), 12'd24, 5'd0, "R4 no rise hold");
      run_vec(run_at(4), 12'd25, 5'd0, "R4 tap0 low hold");
      run_vec(run_at(1), 12'd26, 5'd0, "R4 still held");
      run_vec(run_at(22), 12'd27, 5'd0, "R4 rise back clockwise");
      for (int p = 0; p < N; p++) run_vec(run_at(p), 12'd30, 5'd0, "R4/R5 walk");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule